// File: doc/BRIEF.md
# Serial Write Gatekeeper with Protect Control Register

This block sits between a serial memory's bit engine and its storage array. It keeps an 8-bit control register, and for each data byte the bit engine has decoded it decides whether to acknowledge the byte and let the write go ahead. The register holds two volatile latches that arm writes: a write latch and an arming latch for nonvolatile changes. It also holds six nonvolatile bits: a lock enable, a two-bit watchdog period code, a two-bit block-protect code and a reset-period select.

The nonvolatile bits change only through a three-step unlock sequence on the register address. The first step sets the write latch, the second sets both latches, and the third either commits the new nonvolatile value or cancels the commit. A commit raises a request to the nonvolatile write engine and holds a busy flag until that engine reports completion. While busy, the block refuses all traffic. The nonvolatile bits are modelled as registers that take the committed value when completion is reported.

Array writes are checked against a protected window, which the block-protect code selects from the top of the array. When the external protect pin is high and the lock enable bit is set, the nonvolatile bits can no longer change.

Top module: `nvc_guard`

## Requirements
- R1: After reset every bit of `ctl_o` is 0, and `busy_o`, `ack_vld_o`, `ack_o` and `commit_req_o` are all 0.
- R2: A register byte (address all ones, first data byte of the transaction) of value 02h is acknowledged. The acknowledgement appears on `ack_o` with `ack_vld_o` one cycle after `byte_vld_i`. At the following stop the write latch (`ctl_o[1]`) becomes 1 and no commit is requested.
- R3: A register byte with bit 1 and bit 2 both set (for example 06h) is acknowledged and, at stop, sets both the arming latch (`ctl_o[2]`) and the write latch. The arming latch is never 1 while the write latch is 0.
- R4: With the arming latch set, a register byte with bit 1 = 1 and bit 2 = 0 is acknowledged. At stop it pulses `commit_req_o` for one cycle, sets `busy_o` and clears the arming latch. On `nv_done_i`, `ctl_o` bits 7,6,5,4,3,0 take that byte's bits 7,6,5,4,3,0 and busy drops. The sequence 02h, 06h, 02h therefore clears all nonvolatile bits.
- R5: A third step with bit 2 = 1 cancels the commit: no request is raised, the nonvolatile bits keep their value and the arming latch stays set.
- R6: While the write latch is 0, array writes are not acknowledged, and a register byte with bit 1 = 0 is not acknowledged and changes nothing.
- R7: A register byte with bit 1 = 0 is not acknowledged and, at stop, clears both latches.
- R8: Array addresses are those with address bit 15 = 0. Block-protect code `ctl_o[4:3]` = 00 protects nothing, 01 protects 6000h..7FFFh, 10 protects 4000h..7FFFh and 11 protects 0000h..7FFFh. With the write latch set, an array byte is acknowledged only outside the protected window. Addresses 8000h..FFFEh are never acknowledged.
- R9: An attempted write to a protected array address, with the write latch set, clears the arming latch and leaves the write latch set.
- R10: While `wp_i` is 1 and the lock bit `ctl_o[7]` is 1, a would-be commit byte is not acknowledged and raises no request. At stop the nonvolatile bits stay unchanged, the arming latch is cleared and the write latch stays set.
- R11: While `busy_o` is 1, no byte is acknowledged and no register operation takes effect.
- R12: Only the first data byte of a register transaction is acted on. Later bytes in the same transaction are not acknowledged and are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| byte_vld_i | input | 1 | One decoded write data byte is presented this cycle |
| byte_first_i | input | 1 | The presented byte is the first data byte of its transaction |
| addr_i | input | ADDR_W | Target address of the byte |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition ending the current transaction |
| wp_i | input | 1 | External write-protect pin |
| nv_done_i | input | 1 | Nonvolatile write engine finished |
| ack_vld_o | output | 1 | Acknowledge decision valid (one cycle after a byte) |
| ack_o | output | 1 | Byte acknowledged and allowed |
| commit_req_o | output | 1 | One-cycle request to start a nonvolatile write |
| busy_o | output | 1 | Nonvolatile write in progress |
| ctl_o | output | 8 | Control register: 7 lock, 6:5 watchdog code, 4:3 protect code, 2 arming latch, 1 write latch, 0 reset-period select |

## Verification
On every cycle the assertions check that no byte is acknowledged while busy, with the write latch clear for array targets, or inside the protected window. They also check that the arming latch never stands without the write latch and that a commit request never starts while a previous one is pending. The unlock ordering, the cancel path, the one-way pin lock, the exact committed field values and the window boundaries for every protect code can only be shown by the bench's scenarios. The bench drives these through full register sequences and compares the results against arithmetic expectations.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_SET_BOTH,
    OP_COMMIT,
    OP_REFUSE,
    OP_CLR_WEL
  } reg_op_e;

  localparam int CTL_W   = 8;
  localparam int B_LOCK  = 7;
  localparam int B_BP_HI = 4;
  localparam int B_BP_LO = 3;
  localparam int B_ARM   = 2;
  localparam int B_WEL   = 1;
  localparam logic [CTL_W-1:0] NV_MASK = 8'b1111_1001;
endpackage

// File: rtl/nvc_bp_decode.sv
module nvc_bp_decode (
  input  logic [2:0] addr_hi_i,
  input  logic [1:0] bp_i,
  output logic       in_array_o,
  output logic       prot_o
);
  logic [1:0] quarter;
  logic       raw;
  assign quarter = addr_hi_i[1:0];

  always_comb begin
    in_array_o = ~addr_hi_i[2];
    unique case (bp_i)
      2'b00:   raw = 1'b0;
      2'b01:   raw = (quarter == 2'b11);
      2'b10:   raw = quarter[1];
      default: raw = 1'b1;
    endcase
    prot_o = raw & in_array_o;
  end
endmodule

// File: rtl/nvc_classify.sv
module nvc_classify
  import nvc_pkg::*;
(
  input  logic    bit1_i,
  input  logic    bit2_i,
  input  logic    arm_i,
  input  logic    locked_i,
  output reg_op_e op_o,
  output logic    ack_o
);
  always_comb begin
    if (!bit1_i) begin
      op_o  = OP_CLR_WEL;
      ack_o = 1'b0;
    end else if (bit2_i) begin
      op_o  = OP_SET_BOTH;
      ack_o = 1'b1;
    end else if (arm_i) begin
      op_o  = locked_i ? OP_REFUSE : OP_COMMIT;
      ack_o = ~locked_i;
    end else begin
      op_o  = OP_SET_WEL;
      ack_o = 1'b1;
    end
  end
endmodule

// File: rtl/nvc_commit_track.sv
module nvc_commit_track #(
  parameter int         W      = 8,
  parameter logic [W-1:0] NV_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] nv_in_i,
  input  logic         done_i,
  output logic         busy_o,
  output logic         req_o,
  output logic [W-1:0] nv_o
);
  logic [W-1:0] nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      req_o  <= 1'b0;
      nv_o   <= NV_RST;
      nxt_q  <= NV_RST;
    end else begin
      req_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        req_o  <= 1'b1;
        nxt_q  <= nv_in_i;
      end else if (done_i && busy_o) begin
        busy_o <= 1'b0;
        nv_o   <= nxt_q;
      end
    end
  end

  // R4
  commit_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !$past(busy_o));
endmodule

// File: rtl/nvc_guard.sv
module nvc_guard
  import nvc_pkg::*;
#(
  parameter int               ADDR_W = 16,
  parameter logic [CTL_W-1:0] NV_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld_i,
  input  logic              byte_first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              nv_done_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              commit_req_o,
  output logic              busy_o,
  output logic [CTL_W-1:0]  ctl_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = '1;

  logic             wel_q, arm_q, pend_q;
  reg_op_e          op_q;
  logic [CTL_W-1:0] data_q;
  logic [CTL_W-1:0] nv_q;
  logic             is_reg, in_array, prot, locked, take, ack_d, start;
  reg_op_e          cls_op;
  logic             cls_ack;

  assign is_reg = (addr_i == REG_ADDR);
  assign locked = wp_i & nv_q[B_LOCK];
  assign take   = byte_vld_i & ~busy_o;

  nvc_bp_decode u_bp (
    .addr_hi_i (addr_i[ADDR_W-1 -: 3]),
    .bp_i      (nv_q[B_BP_HI:B_BP_LO]),
    .in_array_o(in_array),
    .prot_o    (prot)
  );

  nvc_classify u_cls (
    .bit1_i  (data_i[1]),
    .bit2_i  (data_i[2]),
    .arm_i   (arm_q),
    .locked_i(locked),
    .op_o    (cls_op),
    .ack_o   (cls_ack)
  );

  assign ack_d = take & (is_reg ? (byte_first_i & cls_ack)
                                : (in_array & wel_q & ~prot));
  assign start = stop_i & pend_q & ~busy_o & (op_q == OP_COMMIT);

  nvc_commit_track #(.W(CTL_W), .NV_RST(NV_RST)) u_trk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .nv_in_i(data_q & NV_MASK),
    .done_i (nv_done_i),
    .busy_o (busy_o),
    .req_o  (commit_req_o),
    .nv_o   (nv_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q     <= 1'b0;
      arm_q     <= 1'b0;
      pend_q    <= 1'b0;
      op_q      <= OP_NONE;
      data_q    <= '0;
      ack_q_clr();
    end else begin
      ack_vld_o <= byte_vld_i;
      ack_o     <= ack_d;
      if (take) begin
        if (is_reg && byte_first_i) begin
          pend_q <= 1'b1;
          op_q   <= cls_op;
          data_q <= data_i;
        end else if (in_array && wel_q && prot) begin
          arm_q <= 1'b0;
        end
      end
      if (stop_i) begin
        pend_q <= 1'b0;
        if (pend_q && !busy_o) begin
          unique case (op_q)
            OP_SET_WEL:  wel_q <= 1'b1;
            OP_SET_BOTH: begin wel_q <= 1'b1; arm_q <= 1'b1; end
            OP_COMMIT,
            OP_REFUSE:   arm_q <= 1'b0;
            OP_CLR_WEL:  begin wel_q <= 1'b0; arm_q <= 1'b0; end
            default:     ;
          endcase
        end
      end
    end
  end

  task automatic ack_q_clr();
    ack_vld_o <= 1'b0;
    ack_o     <= 1'b0;
  endtask

  always_comb begin
    ctl_o        = nv_q & NV_MASK;
    ctl_o[B_ARM] = arm_q;
    ctl_o[B_WEL] = wel_q;
  end

  // R11
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && busy_o) |=> !ack_o);
  // R6
  wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !wel_q && in_array) |=> !ack_o);
  // R8
  bp_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && prot) |=> !ack_o);
  // R3
  arm_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> wel_q);
endmodule

// File: tb/sim_nvc_guard.sv
`timescale 1ns/1ps
module sim_nvc_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0, byte_first = 1'b0, stop = 1'b0, wp = 1'b0, nv_done = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        ack_vld, ack, commit_req, busy;
  logic [7:0]  ctl;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvc_guard u0 (
    .clk(clk), .rst(rst), .byte_vld_i(byte_vld), .byte_first_i(byte_first),
    .addr_i(addr), .data_i(data), .stop_i(stop), .wp_i(wp), .nv_done_i(nv_done),
    .ack_vld_o(ack_vld), .ack_o(ack), .commit_req_o(commit_req), .busy_o(busy), .ctl_o(ctl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d, input logic f,
                     output logic got_ack, output logic got_vld);
    addr = a; data = d; byte_first = f; byte_vld = 1'b1;
    @(negedge clk);
    got_ack = ack; got_vld = ack_vld;
    byte_vld = 1'b0; byte_first = 1'b0;
  endtask

  task automatic send_stop(output logic got_req);
    stop = 1'b1;
    @(negedge clk);
    got_req = commit_req;
    stop = 1'b0;
  endtask

  task automatic finish_nv();
    nv_done = 1'b1;
    @(negedge clk);
    nv_done = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] d, input logic exp_ack, input logic exp_req, input string tag);
    logic a, v, r;
    put(16'hFFFF, d, 1'b1, a, v);
    chk({tag, " ack"}, a, exp_ack);
    send_stop(r);
    chk({tag, " commit_req"}, r, exp_req);
  endtask

  task automatic set_bp(input logic [1:0] bp);
    wreg(8'h06, 1'b1, 1'b0, "R8 arm");
    wreg({3'b000, bp, 3'b010}, 1'b1, 1'b1, "R8 commit");
    finish_nv();
    chk("R8 bp field", ctl[4:3], bp);
  endtask

  function automatic logic exp_arr_ack(input logic [15:0] a, input logic [1:0] bp);
    int low;
    if (a >= 16'h8000) return 1'b0;
    low = (bp == 2'd3) ? 0 : 32'h8000 - int'(bp) * 32'h2000;
    return (int'(a) < low);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, v, r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ctl", ctl, 8'h00);
    chk("R1 busy", busy, 1'b0);
    chk("R1 ack_vld", ack_vld, 1'b0);
    chk("R1 ack", ack, 1'b0);
    chk("R1 commit_req", commit_req, 1'b0);

    // R6: write latch clear gates array and clearing register bytes
    put(16'h1000, 8'h55, 1'b1, a, v); send_stop(r);
    chk("R6 array nack", a, 1'b0);
    chk("R6 ack_vld", v, 1'b1);
    wreg(8'h00, 1'b0, 1'b0, "R6 reg");
    chk("R6 ctl unchanged", ctl, 8'h00);

    // R2
    wreg(8'h02, 1'b1, 1'b0, "R2");
    chk("R2 ctl", ctl, 8'h02);
    // R3
    wreg(8'h06, 1'b1, 1'b0, "R3");
    chk("R3 ctl", ctl, 8'h06);
    // R5 cancel
    wreg(8'h06, 1'b1, 1'b0, "R5");
    chk("R5 ctl", ctl, 8'h06);
    // R4 commit
    wreg(8'hBB, 1'b1, 1'b1, "R4");
    chk("R4 busy", busy, 1'b1);
    chk("R4 ctl before done", ctl, 8'h02);
    // R11 busy rejection
    put(16'h0000, 8'h11, 1'b1, a, v); send_stop(r);
    chk("R11 array nack", a, 1'b0);
    wreg(8'h06, 1'b0, 1'b0, "R11 reg");
    chk("R11 ctl", ctl, 8'h02);
    finish_nv();
    chk("R4 busy after done", busy, 1'b0);
    chk("R4 ctl after done", ctl, 8'hBB);

    // R8 sweep of all protect codes
    for (int bp = 0; bp < 4; bp++) begin
      set_bp(bp[1:0]);
      for (int k = 0; k < 70; k++) begin
        logic [15:0] ad;
        if (k < 64) ad = 16'(k * 32'h400 + (k * 13) % 32'h400);
        else begin
          case (k)
            64: ad = 16'h5FFF; 65: ad = 16'h6000; 66: ad = 16'h3FFF;
            67: ad = 16'h4000; 68: ad = 16'h7FFF; default: ad = 16'h8000;
          endcase
        end
        put(ad, 8'hA5, 1'b1, a, v); send_stop(r);
        chk($sformatf("R8 bp=%0d addr=%04h", bp, ad), a, exp_arr_ack(ad, bp[1:0]));
      end
    end

    // R9 protected write clears the arming latch (protect code is 11)
    wreg(8'h06, 1'b1, 1'b0, "R9 arm");
    put(16'h0100, 8'h00, 1'b1, a, v); send_stop(r);
    chk("R9 nack", a, 1'b0);
    chk("R9 latches", ctl[2:1], 2'b01);

    // R12 second byte of register transaction discarded
    put(16'hFFFF, 8'h06, 1'b1, a, v);
    chk("R12 first ack", a, 1'b1);
    put(16'hFFFF, 8'h00, 1'b0, a, v);
    chk("R12 second nack", a, 1'b0);
    send_stop(r);
    chk("R12 latches", ctl[2:1], 2'b11);

    // R10 one-way lock
    wreg(8'h82, 1'b1, 1'b1, "R10 set lock");
    finish_nv();
    chk("R10 ctl locked value", ctl, 8'h82);
    wp = 1'b1;
    wreg(8'h06, 1'b1, 1'b0, "R10 arm");
    wreg(8'h9A, 1'b0, 1'b0, "R10 refused");
    chk("R10 ctl kept", ctl, 8'h82);
    wp = 1'b0;
    wreg(8'h06, 1'b1, 1'b0, "R4 seq arm");
    wreg(8'h02, 1'b1, 1'b1, "R4 seq commit");
    finish_nv();
    chk("R4 seq clears nv", ctl, 8'h02);

    // R7
    wreg(8'h06, 1'b1, 1'b0, "R7 arm");
    wreg(8'h00, 1'b0, 1'b0, "R7");
    chk("R7 ctl", ctl, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule